// File: doc/BRIEF.md
# Frame-Sync Serial Audio Transmitter

This block sends two channels of converter samples on a single serial data line. It uses the short frame-sync convention: a pulse on the frame clock marks the start of a frame, and the data bits follow on the bit clock. When the frame clock rises, the block captures both channel words. It then lets a programmable number of active bit-clock edges pass and shifts the captured bits out one per edge.

The interface clocks come from outside the block. A primary bit clock and a primary frame clock each have their own pin. Either of them can be replaced by a secondary source taken from one of two general-purpose pins, and the bit clock and frame clock are selected independently. A polarity control picks which pin transition counts as the active bit-clock edge, whatever the source. All pins are synchronised into the system clock domain, and each edge is detected there.

A power-down input stops the interface unless a keep-running option is set. While the interface is stopped, the line stays low.

Top module: `dsp_serial_tx`

## Requirements
- R1: After reset the serial line is low and no transfer is in progress.
- R2: With the offset enabled and set to N (0 to 255), the line is low for the first N active bit-clock edges after a frame-clock rising edge. The first data bit appears on edge N+1.
- R3: When the offset enable is 0, the programmed offset value is ignored and the first data bit appears on the first active edge after the frame-clock rise.
- R4: Channel 1 is sent first, then channel 2, each MSB first, with no gap between the two words. On the active edge after the last bit of channel 2, the line returns low and stays low until the next frame.
- R5: Both channel words are captured at the frame-clock rising edge. Changes on the sample inputs after that edge do not alter the bits of the current frame.
- R6: With the polarity bit 0, the active edge is the rising edge of the selected bit-clock pin. With the polarity bit 1, the active edge is its falling edge. Only one transfer step happens per active edge.
- R7: Bit-clock and frame-clock sources are selected independently: select 0 chooses the primary pin and select 1 chooses a secondary pin. For a secondary source, code 0 uses general-purpose pin 0 and code 1 uses pin 1. Codes 2 and 3 give a clock with no edges, so no data is sent.
- R8: A frame-clock rising edge during the offset or shift phase abandons the current transfer. It recaptures both samples and restarts the offset count from the programmed value.
- R9: While power-down is 1 and keep-running is 0, clock edges are ignored, any transfer is abandoned and the line is low. With keep-running 1, operation continues during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the interface pins |
| rstN | input | 1 | Active-low synchronous reset |
| priBclk | input | 1 | Primary bit-clock pin |
| priWclk | input | 1 | Primary frame-clock pin |
| gpioPin | input | 2 | General-purpose pins usable as secondary clock sources |
| useSecBclk | input | 1 | 1 selects the secondary bit clock |
| useSecWclk | input | 1 | 1 selects the secondary frame clock |
| secBclkSel | input | 2 | Pin code for the secondary bit clock (0, 1 valid) |
| secWclkSel | input | 2 | Pin code for the secondary frame clock (0, 1 valid) |
| bclkInvert | input | 1 | 1 makes the falling pin edge the active edge |
| offsetEn | input | 1 | 1 applies the programmed data-start offset |
| offsetVal | input | 8 | Data-start offset in bit-clock periods |
| pwrDown | input | 1 | Converter powered down |
| keepClocksOn | input | 1 | Keep the interface clocks running during power-down |
| ch1Data | input | SAMPLE_W | Channel 1 sample word |
| ch2Data | input | SAMPLE_W | Channel 2 sample word |
| serialOut | output | 1 | Serial data line |

## Verification
The bench drives slow pin clocks and compares the line after every active edge with a bit-by-bit model. It uses the maximum offset of 255 to catch a counter that wraps or stops one edge early or late. It changes the sample inputs right after the frame start, which exposes a design that shifts live inputs instead of a captured copy. It also raises the frame clock again partway through a word: a design that ignores this finishes the old frame, and one that forgets to reload samples or the offset starts from the wrong place. Reserved pin codes, an inverted bit clock and power-down with and without keep-running are each run through a full frame. A wrong source decode, a wrong edge polarity or missing gating puts data on the line where silence is expected, or puts it one half-period off.

// File: rtl/dsp_tx_pkg.sv
package dsp_tx_pkg;
  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadWord;   // capture both channel words, drive line low
    logic shiftBit;   // present next MSB on the line
    logic clearOut;   // drive line low
  } txStrobe_t;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_OFFSET = 2'd1,
    TX_SHIFT  = 2'd2
  } txState_t;
endpackage

// File: rtl/dsp_tx_clk_sel.sv
module dsp_tx_clk_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       priBclk,
  input  logic       priWclk,
  input  logic [1:0] gpioPin,
  input  logic       useSecBclk,
  input  logic       useSecWclk,
  input  logic [1:0] secBclkSel,
  input  logic [1:0] secWclkSel,
  input  logic       bclkInvert,
  input  logic       pwrDown,
  input  logic       keepClocksOn,
  output logic       bitEdge,
  output logic       frameRise,
  output logic       clkEnable
);
  localparam int LAST = SYNC_STAGES - 1;

  logic rawBclk, rawWclk;
  logic [LAST:0] bSync, wSync;
  logic bPrev, wPrev;

  function automatic logic pickPin(input logic [1:0] code, input logic [1:0] pins);
    case (code)
      2'd0:    pickPin = pins[0];
      2'd1:    pickPin = pins[1];
      default: pickPin = 1'b0;   // reserved: no clock
    endcase
  endfunction

  always_comb begin
    rawBclk = (useSecBclk ? pickPin(secBclkSel, gpioPin) : priBclk) ^ bclkInvert;
    rawWclk = useSecWclk ? pickPin(secWclkSel, gpioPin) : priWclk;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bSync <= '0;
          wSync <= '0;
        end else begin
          bSync <= {bSync[LAST-1:0], rawBclk};
          wSync <= {wSync[LAST-1:0], rawWclk};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bSync <= '0;
          wSync <= '0;
        end else begin
          bSync <= rawBclk;
          wSync <= rawWclk;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev <= 1'b0;
      wPrev <= 1'b0;
    end else begin
      bPrev <= bSync[LAST];
      wPrev <= wSync[LAST];
    end
  end

  assign clkEnable = !pwrDown || keepClocksOn;
  assign bitEdge   = bSync[LAST] && !bPrev && clkEnable;
  assign frameRise = wSync[LAST] && !wPrev && clkEnable;

  // R6: one transfer step per active edge
  assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitEdge |=> !bitEdge);
  assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameRise |=> !frameRise);
endmodule

// File: rtl/dsp_tx_ctrl.sv
module dsp_tx_ctrl
  import dsp_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int OFFSET_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitEdge,
  input  logic                frameRise,
  input  logic                clkEnable,
  input  logic                offsetEn,
  input  logic [OFFSET_W-1:0] offsetVal,
  output txStrobe_t           strobe,
  output logic                xferBusy,
  output logic                inOffset
);
  localparam int TOTAL_BITS = 2 * SAMPLE_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_REMAIN = CNT_W'(TOTAL_BITS - 1);

  txState_t              state, stateNext;
  logic [OFFSET_W-1:0]   offCnt, offCntNext, effOffset;
  logic [CNT_W-1:0]      bitCnt, bitCntNext;

  assign effOffset = offsetEn ? offsetVal : '0;

  always_comb begin
    stateNext  = state;
    offCntNext = offCnt;
    bitCntNext = bitCnt;
    strobe     = '0;
    if (!clkEnable) begin
      stateNext       = TX_IDLE;
      strobe.clearOut = 1'b1;
    end else if (frameRise) begin
      stateNext       = TX_OFFSET;
      offCntNext      = effOffset;
      strobe.loadWord = 1'b1;
    end else if (bitEdge) begin
      case (state)
        TX_OFFSET: begin
          if (offCnt == '0) begin
            strobe.shiftBit = 1'b1;
            bitCntNext      = LAST_REMAIN;
            stateNext       = TX_SHIFT;
          end else begin
            offCntNext = offCnt - 1'b1;
          end
        end
        TX_SHIFT: begin
          if (bitCnt == '0) begin
            strobe.clearOut = 1'b1;
            stateNext       = TX_IDLE;
          end else begin
            strobe.shiftBit = 1'b1;
            bitCntNext      = bitCnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= TX_IDLE;
      offCnt <= '0;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      offCnt <= offCntNext;
      bitCnt <= bitCntNext;
    end
  end

  assign xferBusy = (state != TX_IDLE);
  assign inOffset = (state == TX_OFFSET);

  // R8: a frame start always restarts the offset from the programmed value
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameRise |=> (state == TX_OFFSET) && (offCnt == $past(effOffset)));
  // R9: stopped clocks force the sequencer idle
  assert_gate_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnable |=> !xferBusy);
  // R4: each shift edge consumes exactly one bit of the frame
  assert_bit_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == TX_SHIFT) && clkEnable && !frameRise && bitEdge && (bitCnt != '0)
      |=> bitCnt == $past(bitCnt) - 1'b1);
endmodule

// File: rtl/dsp_tx_datapath.sv
module dsp_tx_datapath
  import dsp_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] ch1Data,
  input  logic [SAMPLE_W-1:0] ch2Data,
  output logic                serialOut
);
  localparam int FRAME_W = 2 * SAMPLE_W;

  logic [FRAME_W-1:0] shiftReg;
  logic               outBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
    end else if (strobe.loadWord) begin
      shiftReg <= {ch1Data, ch2Data};
      outBit   <= 1'b0;
    end else if (strobe.shiftBit) begin
      outBit   <= shiftReg[FRAME_W-1];
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end else if (strobe.clearOut) begin
      outBit   <= 1'b0;
    end
  end

  assign serialOut = outBit;

  // R5: the captured frame only moves on a load or a shift
  assert_hold_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadWord && !strobe.shiftBit |=> $stable(shiftReg));
endmodule

// File: rtl/dsp_serial_tx.sv
module dsp_serial_tx
  import dsp_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int OFFSET_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                priBclk,
  input  logic                priWclk,
  input  logic [1:0]          gpioPin,
  input  logic                useSecBclk,
  input  logic                useSecWclk,
  input  logic [1:0]          secBclkSel,
  input  logic [1:0]          secWclkSel,
  input  logic                bclkInvert,
  input  logic                offsetEn,
  input  logic [OFFSET_W-1:0] offsetVal,
  input  logic                pwrDown,
  input  logic                keepClocksOn,
  input  logic [SAMPLE_W-1:0] ch1Data,
  input  logic [SAMPLE_W-1:0] ch2Data,
  output logic                serialOut
);
  logic      bitEdge, frameRise, clkEnable;
  logic      xferBusy, inOffset;
  txStrobe_t strobe;

  dsp_tx_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) clk_sel_i (
    .clk(clk), .rstN(rstN),
    .priBclk(priBclk), .priWclk(priWclk), .gpioPin(gpioPin),
    .useSecBclk(useSecBclk), .useSecWclk(useSecWclk),
    .secBclkSel(secBclkSel), .secWclkSel(secWclkSel),
    .bclkInvert(bclkInvert), .pwrDown(pwrDown), .keepClocksOn(keepClocksOn),
    .bitEdge(bitEdge), .frameRise(frameRise), .clkEnable(clkEnable)
  );

  dsp_tx_ctrl #(.SAMPLE_W(SAMPLE_W), .OFFSET_W(OFFSET_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .bitEdge(bitEdge), .frameRise(frameRise), .clkEnable(clkEnable),
    .offsetEn(offsetEn), .offsetVal(offsetVal),
    .strobe(strobe), .xferBusy(xferBusy), .inOffset(inOffset)
  );

  dsp_tx_datapath #(.SAMPLE_W(SAMPLE_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ch1Data(ch1Data), .ch2Data(ch2Data), .serialOut(serialOut)
  );

  // R1/R4: no data on the line outside a transfer
  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !xferBusy |-> !serialOut);
  // R2: line held low while the offset runs
  assert_offset_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    inOffset |-> !serialOut);
endmodule

// File: tb/dsp_serial_tx_tb_top.sv
module dsp_serial_tx_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic priBclk = 1'b0, priWclk = 1'b0;
  logic [1:0] gpioPin = 2'b00;
  logic useSecBclk = 1'b0, useSecWclk = 1'b0;
  logic [1:0] secBclkSel = 2'd0, secWclkSel = 2'd0;
  logic bclkInvert = 1'b0, offsetEn = 1'b0;
  logic [7:0] offsetVal = 8'd0;
  logic pwrDown = 1'b0, keepClocksOn = 1'b0;
  logic [W-1:0] ch1Data = '0, ch2Data = '0;
  logic serialOut;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;   // 50 MHz

  dsp_serial_tx #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .priBclk(priBclk), .priWclk(priWclk),
    .gpioPin(gpioPin), .useSecBclk(useSecBclk), .useSecWclk(useSecWclk),
    .secBclkSel(secBclkSel), .secWclkSel(secWclkSel), .bclkInvert(bclkInvert),
    .offsetEn(offsetEn), .offsetVal(offsetVal), .pwrDown(pwrDown),
    .keepClocksOn(keepClocksOn), .ch1Data(ch1Data), .ch2Data(ch2Data),
    .serialOut(serialOut)
  );

  // Fields: off[47:40] en[39] inv[38] useSB[37] useSW[36] sbSel[35:34] swSel[33:32] ch1[31:16] ch2[15:0]
  localparam int NV = 8;
  localparam logic [47:0] VECS [NV] = '{
    {8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'hA5C3, 16'h1234},  // R2 R4
    {8'd3,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'hFFFF, 16'h0000},  // R2
    {8'd5,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h8001, 16'h7FFE},  // R3
    {8'd1,   1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 16'h1357, 16'h9BDF},  // R6
    {8'd2,   1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, 16'h0F0F, 16'hF0F0},  // R7
    {8'd4,   1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'd1, 16'hC0DE, 16'hBEEF},  // R6 R7
    {8'd255, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h5555, 16'hAAAA},  // R2 boundary
    {8'd0,   1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 16'hDEAD, 16'h0001}   // R7
  };

  task automatic check(input logic exp, input string req, input int e);
    tests++;
    if (serialOut !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: serialOut=%b expected %b", req, e, serialOut, exp);
    end
  endtask

  // Route bit/frame clock levels to the selected pins; unused pins held high
  task automatic setPins(input logic b, input logic w);
    priBclk = 1'b1;
    priWclk = 1'b1;
    gpioPin = 2'b11;
    if (!useSecBclk) priBclk = b;
    else if (secBclkSel < 2) gpioPin[secBclkSel[0]] = b;
    else gpioPin = {b, b};
    if (!useSecWclk) priWclk = w;
    else gpioPin[secWclkSel[0]] = w;
  endtask

  task automatic runFrame(input logic [47:0] v, input int abortAt, input bit silent, input string req);
    logic [2*W-1:0] word;
    int effOff, total, base, e, k, idx;
    logic wLvl, inv, exp;
    offsetVal  = v[47:40];
    offsetEn   = v[39];
    bclkInvert = v[38];
    useSecBclk = v[37];
    useSecWclk = v[36];
    secBclkSel = v[35:34];
    secWclkSel = v[33:32];
    ch1Data    = v[31:16];
    ch2Data    = v[15:0];
    inv    = v[38];
    word   = v[31:0];
    effOff = v[39] ? int'(v[47:40]) : 0;
    total  = effOff + 2 * W + 2;
    @(negedge clk);
    setPins(inv, 1'b0);
    repeat (12) @(negedge clk);
    wLvl = 1'b1;
    setPins(inv, wLvl);
    repeat (8) @(negedge clk);
    base = 0;
    e = 0;
    while (e - base < total) begin
      e++;
      setPins(~inv, wLvl);
      repeat (6) @(negedge clk);
      k = e - base - 1;
      idx = k - effOff;
      if (silent || k < effOff || idx >= 2 * W) exp = 1'b0;
      else exp = word[2*W-1-idx];
      check(exp, req, e);
      repeat (2) @(negedge clk);
      if (e == 1) begin
        ch1Data = ~ch1Data;   // R5: late change must not reach this frame
        ch2Data = ~ch2Data;
      end
      if (e == abortAt) begin
        wLvl = 1'b1;          // R8: restart mid-transfer
        base = e;
        word = {ch1Data, ch2Data};
      end else begin
        wLvl = 1'b0;
      end
      setPins(inv, wLvl);
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: line low during and after reset
    tests++;
    if (serialOut !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: serialOut=%b expected 0", serialOut);
    end
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    tests++;
    if (serialOut !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: serialOut=%b expected 0", serialOut);
    end

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) runFrame(VECS[i], 0, 1'b0, "R2 R3 R4 R5 R6 R7 table");

    // R8: second frame start during channel 1 bits
    runFrame({8'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h3C96, 16'h6A5F}, 8, 1'b0, "R8 abort");
    // R8: second frame start during the offset phase
    runFrame({8'd6, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 16'h8421, 16'h1248}, 3, 1'b0, "R8 offset abort");

    // R7: reserved secondary bit-clock codes produce no data
    runFrame({8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 16'hFFFF, 16'hFFFF}, 0, 1'b1, "R7 code2");
    runFrame({8'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 16'hFFFF, 16'hFFFF}, 0, 1'b1, "R7 code3");

    // R9: power-down gating
    pwrDown = 1'b1;
    keepClocksOn = 1'b0;
    runFrame({8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'hFFFF, 16'hFFFF}, 0, 1'b1, "R9 gated");
    keepClocksOn = 1'b1;
    runFrame({8'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'hB00B, 16'h7EED}, 0, 1'b0, "R9 kept on");
    pwrDown = 1'b0;
    keepClocksOn = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule